// File: doc/BRIEF.md
# Multi-Register Transfer Sequencer

This block drives the memory side of a load-multiple or store-multiple instruction. It accepts a register selection mask together with the base register's value and index and five control flags: pre-index, increment, writeback, load, and user-bank. From these it issues one word access per selected register, with the lowest index first and at increasing addresses. It marks every access as sequential or non-sequential, supplies store data from the register file, and returns load data to the register file. It also writes the updated base value back at a fixed point in the sequence.

An external register file follows the block. It reads the register named by `rf_ridx`, performs the writes the block requests, and switches to the user-mode bank while `rf_user_bank` is high. When `psr_restore` pulses, it copies the saved status register into the current one. Memory accepts an access in any cycle in which `mem_req` and `mem_ready` are both high. The block walks the mask at a rate of at most one register per cycle and signals completion with a single-cycle `done`.

Top module: `blkxfer_seq`

## Requirements
- R1: The number of accesses equals the number of set bits in `reg_mask`. An all-zero mask produces exactly one access, to register 15, while the start address and writeback value are computed as if 16 registers were selected.
- R2: With n the access count from R1 and B the base, the first address is as follows. For increment with pre-index it is B+4. For increment with post-index it is B. For decrement it is B−4n, plus 4 when post-indexed.
- R3: Registers are accessed in ascending index order, and each accepted access is followed by the next one at an address 4 higher.
- R4: The writeback value is B+4n when incrementing and B−4n when decrementing.
- R5: For a load with writeback, the base register (`rf_widx` = base index) receives the writeback value in one dedicated cycle before the first access. A loaded base therefore overwrites it later. For a store with writeback, that write occurs in the cycle the first access is accepted.
- R6: `rf_user_bank` is high on every access when the user-bank flag is set on a store, or on a load whose effective mask excludes register 15. It is low otherwise.
- R7: `psr_restore` pulses together with `done` exactly when a load has the user-bank flag set and its effective mask includes register 15.
- R8: The first access of an instruction has `mem_seq` low, and every later access has `mem_seq` high.
- R9: Load accesses assert `mem_norot` and store accesses do not. A load ends with one cycle in which `mem_idle` is high and `mem_req` is low, before `done`.
- R10: Store data for register 15 is the register file's value plus 4, and other registers are stored unchanged. When the base index is 15, B is `base_val` plus 4.
- R11: While `mem_req` is high and `mem_ready` is low, the address and access attributes hold and no register file write is requested.
- R12: After reset, `busy`, `mem_req` and `done` are low. `done` is a single-cycle pulse after the last access or idle cycle, and `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled when not busy) |
| reg_mask | input | 16 | Register selection, bit i selects register i |
| base_val | input | 32 | Current value of the base register |
| base_idx | input | 4 | Index of the base register |
| pre_idx | input | 1 | 1: adjust address before each access |
| incr | input | 1 | 1: addresses grow from base, 0: below base |
| wback | input | 1 | Write the updated base back |
| is_load | input | 1 | 1: load, 0: store |
| user_bank | input | 1 | User-bank / status-restore flag |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the current access |
| mem_we | output | 1 | Access is a write |
| mem_seq | output | 1 | Access is sequential to the previous one |
| mem_norot | output | 1 | Skip unaligned-read rotation |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with `mem_ready` |
| mem_idle | output | 1 | Internal idle cycle ending a load |
| rf_ridx | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data |
| rf_we | output | 1 | Register file write strobe |
| rf_widx | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| rf_user_bank | output | 1 | Use the user-mode register bank |
| psr_restore | output | 1 | Copy the saved status into the current status |

## Verification
The assertions assume three things about the environment. First, `mem_rdata` is meaningful only in the cycle `mem_ready` is high. Second, `start` is the only way into a transfer. Third, `mem_ready` may drop at any time, so address stability is checked only while a request is pending. The stimulus drives inputs on the falling edge and sweeps every combination of the five flags across a set of masks: empty, full, every single bit, alternating patterns and pseudo-random values. It uses base indices 0, 5 and 15 and randomly withheld `mem_ready`. In some runs it holds `start` high with altered inputs throughout the transfer, which exercises the rule that `start` is ignored while busy.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_BASEWR = 3'd1,
    ST_XFER   = 3'd2,
    ST_TAIL   = 3'd3,
    ST_FIN    = 3'd4
  } seq_state_e;
endpackage

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/blkxfer_prienc.sv
module blkxfer_prienc #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/blkxfer_addrgen.sv
module blkxfer_addrgen #(
  parameter int AW         = 32,
  parameter int CW         = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] cnt,
  input  logic          pre_idx,
  input  logic          incr,
  output logic [AW-1:0] first_addr,
  output logic [AW-1:0] wb_addr
);
  localparam int SH = $clog2(WORD_BYTES);
  localparam logic [AW-1:0] WSTEP = AW'(WORD_BYTES);

  logic [AW-1:0] span;

  always_comb begin
    span = AW'(cnt) << SH;
    if (incr) begin
      first_addr = pre_idx ? (base + WSTEP) : base;
      wb_addr    = base + span;
    end else begin
      first_addr = pre_idx ? (base - span) : (base - span + WSTEP);
      wb_addr    = base - span;
    end
  end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq #(
  parameter int AW         = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  parameter int PC_AHEAD   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [NREG-1:0]          reg_mask,
  input  logic [AW-1:0]            base_val,
  input  logic [$clog2(NREG)-1:0]  base_idx,
  input  logic                     pre_idx,
  input  logic                     incr,
  input  logic                     wback,
  input  logic                     is_load,
  input  logic                     user_bank,
  output logic                     busy,
  output logic                     done,
  output logic                     mem_req,
  input  logic                     mem_ready,
  output logic                     mem_we,
  output logic                     mem_seq,
  output logic                     mem_norot,
  output logic [AW-1:0]            mem_addr,
  output logic [AW-1:0]            mem_wdata,
  input  logic [AW-1:0]            mem_rdata,
  output logic                     mem_idle,
  output logic [$clog2(NREG)-1:0]  rf_ridx,
  input  logic [AW-1:0]            rf_rdata,
  output logic                     rf_we,
  output logic [$clog2(NREG)-1:0]  rf_widx,
  output logic [AW-1:0]            rf_wdata,
  output logic                     rf_user_bank,
  output logic                     psr_restore
);
  import blkxfer_pkg::*;

  localparam int IW     = $clog2(NREG);
  localparam int CW     = $clog2(NREG + 1);
  localparam int PC_IDX = NREG - 1;
  localparam logic [IW-1:0]   PC_SEL = IW'(PC_IDX);
  localparam logic [AW-1:0]   WSTEP  = AW'(WORD_BYTES);
  localparam logic [AW-1:0]   PC_ADJ = AW'(PC_AHEAD);
  localparam logic [NREG-1:0] PC_OH  = NREG'(1) << PC_IDX;

  // ---------------- start-time decode ----------------
  logic            mask_empty;
  logic [NREG-1:0] eff_mask;
  logic [CW-1:0]   pop_cnt;
  logic [CW-1:0]   eff_cnt;
  logic [AW-1:0]   base_adj;
  logic [AW-1:0]   first_addr;
  logic [AW-1:0]   wb_addr;
  logic            ub_eff;
  logic            psr_eff;
  logic            start_acc;

  blkxfer_popcnt #(.N(NREG), .CW(CW)) u_pop (
    .vec (reg_mask),
    .cnt (pop_cnt)
  );

  always_comb begin
    mask_empty = (reg_mask == '0);
    eff_mask   = mask_empty ? PC_OH : reg_mask;
    eff_cnt    = mask_empty ? CW'(NREG) : pop_cnt;
    base_adj   = base_val + ((base_idx == PC_SEL) ? PC_ADJ : '0);
    ub_eff     = user_bank && (!is_load || !eff_mask[PC_IDX]);
    psr_eff    = user_bank && is_load && eff_mask[PC_IDX];
  end

  blkxfer_addrgen #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_addr (
    .base       (base_adj),
    .cnt        (eff_cnt),
    .pre_idx    (pre_idx),
    .incr       (incr),
    .first_addr (first_addr),
    .wb_addr    (wb_addr)
  );

  // ---------------- state ----------------
  seq_state_e      st_q, st_d;
  logic [NREG-1:0] rem_q, rem_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [AW-1:0]   wbv_q;
  logic [IW-1:0]   bidx_q;
  logic            load_q, wb_q, ub_q, psr_q;
  logic            first_q, first_d;
  logic            ld_en;
  logic            step_en;

  // ---------------- walk ----------------
  logic [IW-1:0]   cur_idx;
  logic [NREG-1:0] cur_oh;
  logic [NREG-1:0] rem_nxt;
  logic            acc;
  logic            last_acc;

  blkxfer_prienc #(.N(NREG), .IW(IW)) u_pick (
    .vec (rem_q),
    .idx (cur_idx)
  );

  always_comb begin
    cur_oh   = NREG'(1) << cur_idx;
    rem_nxt  = rem_q & ~cur_oh;
    acc      = (st_q == ST_XFER) && mem_ready;
    last_acc = acc && (rem_nxt == '0);
  end

  // ---------------- next state ----------------
  always_comb begin
    st_d      = st_q;
    start_acc = (st_q == ST_IDLE) && start;
    ld_en     = start_acc;
    step_en   = acc;
    rem_d     = ld_en ? eff_mask : rem_nxt;
    addr_d    = ld_en ? first_addr : (addr_q + WSTEP);
    first_d   = ld_en;
    unique case (st_q)
      ST_IDLE:   if (start) st_d = (is_load && wback) ? ST_BASEWR : ST_XFER;
      ST_BASEWR: st_d = ST_XFER;
      ST_XFER:   if (last_acc) st_d = load_q ? ST_TAIL : ST_FIN;
      ST_TAIL:   st_d = ST_FIN;
      ST_FIN:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbv_q  <= '0;
      bidx_q <= '0;
      load_q <= 1'b0;
      wb_q   <= 1'b0;
      ub_q   <= 1'b0;
      psr_q  <= 1'b0;
    end else if (ld_en) begin
      wbv_q  <= wb_addr;
      bidx_q <= base_idx;
      load_q <= is_load;
      wb_q   <= wback;
      ub_q   <= ub_eff;
      psr_q  <= psr_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      addr_q  <= '0;
      first_q <= 1'b0;
    end else if (ld_en || step_en) begin
      rem_q   <= rem_d;
      addr_q  <= addr_d;
      first_q <= first_d;
    end
  end

  // ---------------- outputs ----------------
  always_comb begin
    busy         = (st_q != ST_IDLE);
    done         = (st_q == ST_FIN);
    psr_restore  = done && psr_q;
    mem_req      = (st_q == ST_XFER);
    mem_we       = mem_req && !load_q;
    mem_norot    = mem_req && load_q;
    mem_seq      = mem_req && !first_q;
    mem_addr     = addr_q;
    mem_idle     = (st_q == ST_TAIL);
    rf_ridx      = cur_idx;
    mem_wdata    = rf_rdata + ((cur_idx == PC_SEL) ? PC_ADJ : '0);
    rf_user_bank = mem_req && ub_q;

    rf_we    = 1'b0;
    rf_widx  = bidx_q;
    rf_wdata = wbv_q;
    if (st_q == ST_BASEWR) begin
      rf_we = 1'b1;
    end else if (acc && load_q) begin
      rf_we    = 1'b1;
      rf_widx  = cur_idx;
      rf_wdata = mem_rdata;
    end else if (acc && first_q && wb_q) begin
      rf_we = 1'b1;
    end
  end
endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_acc,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_seq,
  input logic          mem_we,
  input logic          mem_idle,
  input logic [AW-1:0] mem_addr,
  input logic          rf_we,
  input logic          rf_user_bank,
  input logic          psr_restore
);
  localparam logic [AW-1:0] STEP = AW'(4);

  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_no_write_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |-> !rf_we);

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (!mem_req || (mem_addr == $past(mem_addr) + STEP)));

  assert_seq_after_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (!mem_req || mem_seq));

  assert_first_nonseq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> !mem_seq);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_restore_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    psr_restore |-> done);

  assert_idle_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_idle |-> (!mem_req && busy));

  assert_bank_during_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_user_bank |-> mem_req);
endmodule

bind blkxfer_seq blkxfer_seq_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_acc    (start_acc),
  .busy         (busy),
  .done         (done),
  .mem_req      (mem_req),
  .mem_ready    (mem_ready),
  .mem_seq      (mem_seq),
  .mem_we       (mem_we),
  .mem_idle     (mem_idle),
  .mem_addr     (mem_addr),
  .rf_we        (rf_we),
  .rf_user_bank (rf_user_bank),
  .psr_restore  (psr_restore)
);

// File: tb/tb_blkxfer_seq.sv
`timescale 1ns/1ps
module tb_blkxfer_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] reg_mask;
  logic [31:0] base_val;
  logic [3:0]  base_idx;
  logic        pre_idx, incr, wback, is_load, user_bank;
  logic        busy, done, mem_req, mem_ready, mem_we, mem_seq, mem_norot, mem_idle;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata;
  logic [3:0]  rf_ridx, rf_widx;
  logic        rf_we, rf_user_bank, psr_restore;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  assign mem_rdata = ~mem_addr ^ 32'h5A5A_0000;
  assign rf_rdata  = {16'hC0DE, 12'h000, rf_ridx};

  blkxfer_seq dut (.*);

  function automatic logic [31:0] nxt_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_one(input logic [15:0] m, input logic [31:0] b, input logic [3:0] bi,
                         input bit pr, input bit up, input bit wb, input bit ld, input bit ub,
                         input bit stall, input bit hold);
    logic [15:0] eff;
    int n, k, ph, guard;
    logic [31:0] bas, a, wbv;
    bit ubeff, psrx;
    logic [3:0] cur;
    eff = (m == 16'h0) ? 16'h8000 : m;
    n = 0;
    for (int i = 0; i < 16; i++) n += eff[i];
    if (m == 16'h0) n = 16;
    bas = b + ((bi == 4'd15) ? 32'd4 : 32'd0);
    a   = up ? (pr ? bas + 32'd4 : bas) : (bas - 32'(4 * n) + (pr ? 32'd0 : 32'd4));
    wbv = up ? bas + 32'(4 * n) : bas - 32'(4 * n);
    ubeff = ub && (!ld || !eff[15]);
    psrx  = ub && ld && eff[15];

    reg_mask = m; base_val = b; base_idx = bi;
    pre_idx = pr; incr = up; wback = wb; is_load = ld; user_bank = ub;
    start = 1'b1;
    @(negedge clk);
    if (hold) begin
      reg_mask = ~m; base_val = ~b; is_load = ~ld; wback = ~wb; user_bank = ~ub;
    end else begin
      start = 1'b0;
    end
    chk(busy === 1'b1, "R12 busy after start", 32'(busy), 32'd1);
    k = 0; ph = (ld && wb) ? 0 : 1; guard = 0;
    while (ph != 4 && guard < 200) begin
      guard++;
      mem_ready = stall ? (nxt_rand() >> 13) % 4 != 0 : 1'b1;
      #1;
      case (ph)
        0: begin
          chk(rf_we && !mem_req && rf_widx == bi && rf_wdata == wbv, "R5/R4 load base write",
              rf_wdata, wbv);
          ph = 1;
        end
        1: begin
          cur = 4'd0;
          for (int i = 15; i >= 0; i--) if (eff[i]) cur = 4'(i);
          chk(mem_req === 1'b1, "R1 access expected", 32'(mem_req), 32'd1);
          chk(rf_ridx == cur, "R3 register order", 32'(rf_ridx), 32'(cur));
          chk(mem_addr == a, "R2/R3 address", mem_addr, a);
          chk(mem_seq == (k > 0), "R8 sequential flag", 32'(mem_seq), 32'(k > 0));
          chk(mem_norot == ld && mem_we == !ld, "R9 norot/we", {mem_norot, mem_we}, {ld, !ld});
          chk(rf_user_bank == ubeff, "R6 user bank", 32'(rf_user_bank), 32'(ubeff));
          if (!ld)
            chk(mem_wdata == {16'hC0DE, 12'h000, cur} + ((cur == 4'd15) ? 32'd4 : 32'd0),
                "R10 store data", mem_wdata, {16'hC0DE, 12'h000, cur});
          if (mem_ready) begin
            if (ld)
              chk(rf_we && rf_widx == cur && rf_wdata == (~a ^ 32'h5A5A_0000), "R9 load write",
                  rf_wdata, ~a ^ 32'h5A5A_0000);
            else if (k == 0 && wb)
              chk(rf_we && rf_widx == bi && rf_wdata == wbv, "R5/R4 store writeback", rf_wdata, wbv);
            else
              chk(!rf_we, "R5 no extra write", 32'(rf_we), 32'd0);
            eff[cur] = 1'b0; a = a + 32'd4; k++;
            if (eff == 16'h0) ph = ld ? 2 : 3;
          end else begin
            chk(!rf_we, "R11 no write while stalled", 32'(rf_we), 32'd0);
          end
        end
        2: begin
          chk(mem_idle && !mem_req && !done, "R9 tail idle", {mem_idle, mem_req}, 32'd2);
          ph = 3;
        end
        default: begin
          chk(done === 1'b1 && !mem_req, "R12 done pulse", 32'(done), 32'd1);
          chk(psr_restore == psrx, "R7 status restore", 32'(psr_restore), 32'(psrx));
          chk(k == ((m == 16'h0) ? 1 : n), "R1 access count", 32'(k), 32'(n));
          start = 1'b0;
          ph = 4;
        end
      endcase
      @(negedge clk);
    end
    chk(guard < 200, "R12 completion", 32'(guard), 32'd200);
    chk(!busy && !done, "R12 idle after done", {busy, done}, 32'd0);
  endtask

  initial begin
    logic [15:0] masks [28];
    int run;
    rst_n = 1'b0; start = 1'b0; reg_mask = '0; base_val = '0; base_idx = '0;
    pre_idx = 0; incr = 0; wback = 0; is_load = 0; user_bank = 0; mem_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req && !done && !rf_we, "R12 reset state", {busy, mem_req, done}, 32'd0);

    masks[0] = 16'h0000; masks[1] = 16'hFFFF; masks[2] = 16'h8001; masks[3] = 16'h00F0;
    masks[4] = 16'hAAAA; masks[5] = 16'h5555; masks[6] = 16'h7FFF; masks[7] = 16'h8000;
    for (int i = 0; i < 16; i++) masks[8 + i] = 16'h1 << i;
    for (int i = 24; i < 28; i++) masks[i] = nxt_rand() >> 8;

    run = 0;
    for (int mi = 0; mi < 28; mi++) begin
      for (int f = 0; f < 32; f++) begin
        logic [3:0] bi;
        logic [31:0] b;
        bi = (run % 3 == 0) ? 4'd0 : ((run % 3 == 1) ? 4'd5 : 4'd15);
        b  = (nxt_rand() & 32'h00FF_FFFC) | 32'h0000_0100;
        run_one(masks[mi], b, bi, f[0], f[1], f[2], f[3], f[4], run % 2 == 1, run % 5 == 2);
        run++;
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule